// File: doc/BRIEF.md
# Half-Rate Tomlinson-Harashima Transmit Precoder

This block is the digital core of a transmit equalizer that removes post-cursor intersymbol interference before the symbols reach the line. Each data symbol is mapped to an odd amplitude level. The block subtracts a weighted sum of the symbols it has already precoded, using a recursive filter with eight taps. It then folds the difference back into a fixed amplitude window with a modulo wrap, so the transmitted swing stays bounded whatever the tap weights are. The receiver only needs a matching modulo slicer.

Two consecutive symbols are handled per clock: an earlier (even) lane and a later (odd) lane. The sum over taps three and up for the next beat is formed one beat early from history that is already settled. Only the near taps stay in the loop. The odd lane takes the even lane's fresh result as its first-tap term within the same cycle. The outcome is bit-exact with a one-symbol-per-step recursion.

Input beats use a valid/ready handshake. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its two results appear on the output one cycle later and stay there until `out_ready` is high. `in_ready` drops only while an output is held and not taken, so the history advances exactly once per accepted beat. Tap weights, reset and the mode select are plain control pins.

Top module: `th_precoder`

## Requirements
- R1: With `pam4` low, bit 0 of each lane code selects the level: 0 gives -1 and 1 gives +1. Bit 1 of each lane code has no effect. Outputs are signed, with one level unit equal to 32 (2^(CW-1)).
- R2: With `pam4` high, each 2-bit lane code maps in Gray order: 00 to -3, 01 to -1, 11 to +1, 10 to +3.
- R3: `in_sym[1:0]` is the earlier symbol and `in_sym[3:2]` the later one. `out_even` and `out_odd` carry their precoded results in the same order.
- R4: For symbol n with level d, the precoded value is computed as follows. Take d*1024 minus the sum over k=1..8 of w_k*x[n-k], where x are earlier outputs in units of 1/32. Wrap this into [-2048,2048) in 2-level mode or [-4096,4096) in 4-level mode. Divide by 32, rounding toward minus infinity. The result equals this full-rate recursion, including across lane and beat boundaries.
- R5: Outputs always lie in [-64,63] in 2-level mode and in [-128,127] in 4-level mode, for any tap weights.
- R6: When all tap weights are zero, each output equals its mapped level times 32.
- R7: A write with `cfg_we` high stores the signed 6-bit `cfg_wdata` as the weight of tap `cfg_addr`+1, in units of 1/32. Reset zeroes all weights. Weights are written while no beats are streaming, after a reset.
- R8: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. An accepted beat makes `out_valid` high on the next cycle.
- R9: While `out_valid` is high and `out_ready` is low, both outputs and `out_valid` hold. Stalled cycles do not change the feedback history.
- R10: Synchronous active-high `rst` clears the history, the weights and `out_valid`. The first beats after reset behave as if all earlier symbols were zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pam4 | input | 1 | 0: two-level symbols, 1: four-level symbols |
| cfg_we | input | 1 | Tap weight write strobe |
| cfg_addr | input | 3 | Tap index minus one |
| cfg_wdata | input | 6 | Signed tap weight |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take a beat |
| in_sym | input | 4 | Two lane codes, earlier lane in bits 1:0 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink takes the output beat |
| out_even | output | 8 | Signed precoded earlier symbol |
| out_odd | output | 8 | Signed precoded later symbol |

## Verification
The first patterns use zero taps in both modes. They isolate the level mapping, the Gray order and lane ordering from any feedback. Random taps with random symbols in each mode are then checked against a one-symbol-at-a-time model. Errors in the odd lane's same-cycle first-tap term, or in the precomputed far sums, show up here. Full-scale taps force frequent modulo wraps, which separates a correct wrap window in each mode from an off-by-one range. Heavy output back-pressure and a reset in the middle of a stream show whether stalls or reset disturb the history.

// File: rtl/th_pkg.sv
package th_pkg;
  typedef enum logic {
    PAM2 = 1'b0,
    PAM4 = 1'b1
  } pam_mode_e;

  // odd signal level in symbol units, -3..+3
  typedef logic signed [2:0] level_t;

  localparam int LANES = 2;
endpackage

// File: rtl/th_mapper.sv
module th_mapper
  import th_pkg::*;
(
  input  logic [1:0] code,
  input  pam_mode_e  mode,
  output level_t     lvl
);
  always_comb begin
    if (mode == PAM4) begin
      unique case (code)
        2'b00:   lvl = -3'sd3;
        2'b01:   lvl = -3'sd1;
        2'b11:   lvl = 3'sd1;
        default: lvl = 3'sd3;
      endcase
    end else begin
      lvl = code[0] ? 3'sd1 : -3'sd1;
    end
  end

  logic unused_code_hi;
  assign unused_code_hi = code[1] & (mode == PAM2);
endmodule

// File: rtl/th_tap_sum.sv
module th_tap_sum #(
  parameter int CNT = 2,
  parameter int CW  = 6,
  parameter int XW  = 8,
  parameter int AW  = 19
) (
  input  logic signed [CW-1:0] wt  [CNT],
  input  logic signed [XW-1:0] smp [CNT],
  output logic signed [AW-1:0] sum
);
  logic signed [AW-1:0] term [CNT];

  for (genvar k = 0; k < CNT; k++) begin : g_term
    assign term[k] = AW'(wt[k]) * AW'(smp[k]);
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < CNT; k++) sum = sum + term[k];
  end
endmodule

// File: rtl/th_wrap_lane.sv
module th_wrap_lane
  import th_pkg::*;
#(
  parameter int CW = 6,
  parameter int AW = 19
) (
  input  level_t               lvl,
  input  pam_mode_e            mode,
  input  logic signed [AW-1:0] acc,
  output logic signed [CW+1:0] x
);
  localparam int FB = CW - 1;
  localparam int SH = 2 * FB;

  logic signed [AW-1:0] diff;

  assign diff = (AW'(lvl) <<< SH) - acc;

  // the wrap keeps the low bits of the window, the floor drops FB fraction bits
  always_comb begin
    if (mode == PAM4) x = diff[SH+2:SH-FB];
    else              x = {diff[SH+1], diff[SH+1:SH-FB]};
  end

  logic unused_bits;
  assign unused_bits = ^{diff[AW-1:SH+3], diff[SH-FB-1:0]};
endmodule

// File: rtl/th_precoder.sv
module th_precoder
  import th_pkg::*;
#(
  parameter int NTAP = 8,  // at least 4
  parameter int CW   = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pam4,
  input  logic                          cfg_we,
  input  logic [$clog2(NTAP)-1:0]       cfg_addr,
  input  logic [CW-1:0]                 cfg_wdata,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [2*LANES-1:0]            in_sym,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic signed [CW+1:0]          out_even,
  output logic signed [CW+1:0]          out_odd
);
  localparam int FB   = CW - 1;
  localparam int XW   = CW + 2;
  localparam int AW   = CW + XW + $clog2(NTAP) + 2;
  localparam int HD   = NTAP - 2;
  localparam int LIM2 = 1 << CW;

  pam_mode_e mode;
  logic      fire;

  assign mode     = pam_mode_e'(pam4);
  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  // tap weights, index 0 holds tap 1
  logic signed [CW-1:0] w_q [NTAP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NTAP; k++) w_q[k] <= '0;
    end else if (cfg_we) begin
      w_q[cfg_addr] <= cfg_wdata;
    end
  end

  // level mapping per lane
  level_t lvl [LANES];

  for (genvar ln = 0; ln < LANES; ln++) begin : g_map
    th_mapper u_map (
      .code (in_sym[2*ln +: 2]),
      .mode (mode),
      .lvl  (lvl[ln])
    );
  end

  // history: hist_q[0] is the newest precoded symbol
  logic signed [XW-1:0] hist_q [HD];
  logic signed [AW-1:0] far_e_q, far_o_q;
  logic signed [AW-1:0] far_e_nx, far_o_nx;
  logic signed [AW-1:0] near_e, near_o;
  logic signed [AW-1:0] acc_e, acc_o;
  logic signed [XW-1:0] x_e, x_o;

  // near terms of the even lane: taps 1 and 2
  logic signed [CW-1:0] wn_e [2];
  logic signed [XW-1:0] sn_e [2];
  // near terms of the odd lane: taps 1..3, tap 1 on this beat's even result
  logic signed [CW-1:0] wn_o [3];
  logic signed [XW-1:0] sn_o [3];
  // far terms formed one beat ahead
  logic signed [CW-1:0] wf_e [NTAP-2];
  logic signed [XW-1:0] sf_e [NTAP-2];
  logic signed [CW-1:0] wf_o [NTAP-3];
  logic signed [XW-1:0] sf_o [NTAP-3];

  assign wn_e[0] = w_q[0];
  assign wn_e[1] = w_q[1];
  assign sn_e[0] = hist_q[0];
  assign sn_e[1] = hist_q[1];

  assign wn_o[0] = w_q[0];
  assign wn_o[1] = w_q[1];
  assign wn_o[2] = w_q[2];
  assign sn_o[0] = x_e;
  assign sn_o[1] = hist_q[0];
  assign sn_o[2] = hist_q[1];

  for (genvar j = 0; j < NTAP - 2; j++) begin : g_far_e
    assign wf_e[j] = w_q[j+2];
    assign sf_e[j] = hist_q[j];
  end

  for (genvar j = 0; j < NTAP - 3; j++) begin : g_far_o
    assign wf_o[j] = w_q[j+3];
    assign sf_o[j] = hist_q[j];
  end

  th_tap_sum #(.CNT(2), .CW(CW), .XW(XW), .AW(AW)) u_near_e (
    .wt (wn_e), .smp (sn_e), .sum (near_e)
  );

  th_tap_sum #(.CNT(3), .CW(CW), .XW(XW), .AW(AW)) u_near_o (
    .wt (wn_o), .smp (sn_o), .sum (near_o)
  );

  th_tap_sum #(.CNT(NTAP-2), .CW(CW), .XW(XW), .AW(AW)) u_far_e (
    .wt (wf_e), .smp (sf_e), .sum (far_e_nx)
  );

  th_tap_sum #(.CNT(NTAP-3), .CW(CW), .XW(XW), .AW(AW)) u_far_o (
    .wt (wf_o), .smp (sf_o), .sum (far_o_nx)
  );

  assign acc_e = far_e_q + near_e;
  assign acc_o = far_o_q + near_o;

  th_wrap_lane #(.CW(CW), .AW(AW)) u_lane_e (
    .lvl (lvl[0]), .mode (mode), .acc (acc_e), .x (x_e)
  );

  th_wrap_lane #(.CW(CW), .AW(AW)) u_lane_o (
    .lvl (lvl[1]), .mode (mode), .acc (acc_o), .x (x_o)
  );

  // state update on accepted beats only
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HD; k++) hist_q[k] <= '0;
      far_e_q   <= '0;
      far_o_q   <= '0;
      out_valid <= 1'b0;
      out_even  <= '0;
      out_odd   <= '0;
    end else begin
      if (fire) begin
        hist_q[0] <= x_o;
        hist_q[1] <= x_e;
        for (int k = 2; k < HD; k++) hist_q[k] <= hist_q[k-2];
        far_e_q  <= far_e_nx;
        far_o_q  <= far_o_nx;
        out_even <= x_e;
        out_odd  <= x_o;
      end
      if (fire)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_even) && $stable(out_odd));

  // R8
  accept_out_chk: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  // R10
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R6
  bypass_even_chk: assert property (@(posedge clk) disable iff (rst)
    acc_e == '0 |-> x_e == (XW'(lvl[0]) <<< FB));

  // R5
  range_two_chk: assert property (@(posedge clk) disable iff (rst)
    mode == PAM2 |-> (x_e >= -LIM2) && (x_e < LIM2) && (x_o >= -LIM2) && (x_o < LIM2));
endmodule

// File: tb/sim_th_precoder.sv
`timescale 1ns/1ps
module sim_th_precoder;
  localparam int NTAP = 8;
  localparam int CW   = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              pam4 = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_addr = '0;
  logic [CW-1:0]     cfg_wdata = '0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [3:0]        in_sym = '0;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic signed [7:0] out_even, out_odd;

  always #2.5 clk = ~clk;

  th_precoder #(.NTAP(NTAP), .CW(CW)) u0 (
    .clk, .rst, .pam4, .cfg_we, .cfg_addr, .cfg_wdata,
    .in_valid, .in_ready, .in_sym, .out_valid, .out_ready,
    .out_even, .out_odd
  );

  int    n_chk = 0;
  int    n_bad = 0;
  int    taps [NTAP];
  int    hist [NTAP];
  int    exp_q [$];
  string tag_q [$];
  string cur_tag = "";
  int    bp_pct = 0;
  int    iv_pct = 100;
  bit    done = 0;

  task automatic check(string tag, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // R1 R2 level mapping
  function automatic int lvl_of(logic [1:0] c, logic m4);
    if (!m4) return c[0] ? 1 : -1;
    case (c)
      2'b00:   return -3;
      2'b01:   return -1;
      2'b11:   return 1;
      default: return 3;
    endcase
  endfunction

  // R4 one symbol of the full-rate recursion
  function automatic int ref_step(int lvl, logic m4);
    int acc, v, span, vw, x;
    acc = 0;
    for (int k = 0; k < NTAP; k++) acc += taps[k] * hist[k];
    v    = lvl * 1024 - acc;
    span = m4 ? 8192 : 4096;
    vw   = ((v + span / 2) % span + span) % span - span / 2;
    x    = vw >>> 5;
    for (int k = NTAP - 1; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = x;
    return x;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    exp_q.delete(); tag_q.delete();
    for (int k = 0; k < NTAP; k++) begin hist[k] = 0; taps[k] = 0; end
    #1;
    check("R10", out_valid, 0);
    check("R8", in_ready, 1);
  endtask

  // kind 0: zero, 1: random, 2: full scale
  task automatic load_taps(int kind);
    for (int k = 0; k < NTAP; k++) begin
      int v;
      if (kind == 0) v = 0;
      else if (kind == 1) v = int'($urandom_range(0, 63)) - 32;
      else v = ($urandom_range(0, 1) != 0) ? 31 : -32;
      taps[k] = v;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 3'(k); cfg_wdata = CW'(v);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // driver: pushes the expected pair for every accepted beat
  task automatic drive_beats(int n, logic m4);
    int got;
    got = 0;
    @(negedge clk);
    pam4 = m4;
    while (got < n) begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 99) >= bp_pct);
      in_valid  = ($urandom_range(0, 99) < iv_pct);
      in_sym    = 4'($urandom);
      #1;
      if (in_valid && in_ready) begin
        int e, o;
        e = ref_step(lvl_of(in_sym[1:0], m4), m4);
        o = ref_step(lvl_of(in_sym[3:2], m4), m4);
        exp_q.push_back(e);
        exp_q.push_back(o);
        tag_q.push_back(cur_tag);
        got++;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) begin
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      #3;
    end
    check("R8", exp_q.size(), 0);
  endtask

  // monitor: pops and compares as results leave the block
  logic              hold = 1'b0;
  logic signed [7:0] he, ho;

  always @(negedge clk) begin
    #2;
    if (rst) begin
      hold = 1'b0;
    end else begin
      if (hold) begin
        check("R9", out_valid, 1);
        check("R9", out_even, he);
        check("R9", out_odd, ho);
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() < 2) begin
          check("R8", 1, 0);
        end else begin
          int e, o, lim;
          string t;
          e = exp_q.pop_front();
          o = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, out_even, e);
          check(t, out_odd, o);
          lim = pam4 ? 128 : 64;
          check("R5", int'(out_even >= -lim && out_even < lim && out_odd >= -lim && out_odd < lim), 1);
        end
      end
      hold = out_valid && !out_ready;
      he = out_even;
      ho = out_odd;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    do_reset();
    // zero taps: pure mapping and lane order
    cur_tag = "R1 R3 R6";
    load_taps(0);
    drive_beats(40, 1'b0);
    drain();
    cur_tag = "R2 R3 R6";
    drive_beats(40, 1'b1);
    drain();
    // random taps, both modes, with back-pressure
    bp_pct = 30; iv_pct = 70;
    do_reset();
    cur_tag = "R4 R7";
    load_taps(1);
    drive_beats(300, 1'b0);
    drain();
    do_reset();
    load_taps(1);
    drive_beats(300, 1'b1);
    drain();
    // full-scale taps: frequent wraps
    do_reset();
    cur_tag = "R5 R4";
    load_taps(2);
    drive_beats(200, 1'b1);
    drain();
    do_reset();
    load_taps(2);
    drive_beats(200, 1'b0);
    drain();
    // heavy stalls, then reset in mid-stream
    bp_pct = 70; iv_pct = 100;
    do_reset();
    cur_tag = "R9 R4";
    load_taps(1);
    drive_beats(150, 1'b1);
    do_reset();
    bp_pct = 20;
    cur_tag = "R10 R4";
    load_taps(1);
    drive_beats(100, 1'b0);
    drain();
    finish_run();
  end
endmodule